// File: doc/BRIEF.md
# Frame-Driven Bootload Command Engine

This block sits between a CAN receive path and a memory programming sequencer in a node that can be reprogrammed over the bus. It takes decoded extended frames, each with an identifier, a length code and up to eight payload bytes. Two identifier bits classify every frame. One bit chooses between a write and a read. The other chooses whether the payload is aimed at an eight-byte control set or at target memory.

The control set holds a 24-bit address pointer, a reserved byte, a mode byte, a command byte and two parameter bytes. Writes of memory data become write requests to the downstream sequencer. These requests are gated by an unlock bit, carry erase hints, and may step the pointer. A control write can also fire a one-cycle command strobe.

A build parameter picks the variant. In the read/write variant, reads of memory and of the control set produce response frames, and write frames may be acknowledged with an empty frame. In the write-only variant, the block never transmits.

Top module: `bootcmd_engine`

## Requirements
- R1: Identifier bit 1 selects the operation (0 = write, 1 = read) and identifier bit 0 selects the target (0 = control set, 1 = memory data).
- R2: A control write loads payload byte i (rx_data[8i+7:8i]) into control byte i only for i below the length code (capped at 8). Byte order is: pointer low, pointer middle, pointer upper, reserved, mode, command, parameter low, parameter high. Bytes at or above the length keep their value.
- R3: After reset the pointer, the command and the parameter bytes are 0, and the mode byte is 1Ch. Mode bits are: bit 0 unlock, bit 1 erase-only, bit 2 auto-erase, bit 3 auto-increment, bit 4 acknowledge.
- R4: A memory write frame arriving while the unlock bit is 0 issues no memory request.
- R5: An unlocked memory write with a non-zero length issues one write request carrying the pointer, the length and the payload. Its erase flag is set when auto-erase is on and the pointer is a multiple of 64. Its erase-only flag copies mode bit 1.
- R6: With auto-increment on, the pointer advances by the bytes transferred after each memory request, modulo 2^24. With auto-increment off, the pointer is unchanged.
- R7: The command byte in effect after each control write is acted on. 01h pulses dev_reset, 02h pulses chk_init and 03h pulses chk_run, each for one cycle. Every other code pulses none of them.
- R8: In the read/write variant, every write frame is answered by a frame with length 0 when the acknowledge bit is 1. For a control write, the acknowledge bit used is the one in effect after that write. No answer is sent when the bit is 0.
- R9: In the read/write variant, a memory read issues an 8-byte read request at the pointer. The returned data is sent as an 8-byte frame one cycle after mem_rvalid.
- R10: In the read/write variant, a control read sends an 8-byte frame laid out as: pointer in bytes 0..2, the mode byte in byte 4, and zero in bytes 3, 5, 6 and 7.
- R11: In the write-only variant, read frames issue no memory request and no frame is ever transmitted.
- R12: A received frame is held in a one-entry buffer while mem_idle is 0 (or a read is outstanding). rx_busy is 1 while the buffer is full. The frame is acted on in the first cycle the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received frame strobe |
| rx_id | input | 29 | Extended identifier |
| rx_len | input | 4 | Data length code |
| rx_data | input | 64 | Payload, byte 0 in bits 7:0 |
| rx_busy | output | 1 | Frame buffer full |
| mem_idle | input | 1 | Sequencer ready for a request |
| mem_req | output | 1 | Memory request strobe |
| mem_wr | output | 1 | 1 = write, 0 = read |
| mem_erase | output | 1 | Erase row before writing |
| mem_erase_only | output | 1 | Erase without writing |
| mem_addr | output | 24 | Request address |
| mem_len | output | 4 | Request byte count |
| mem_wdata | output | 64 | Write payload |
| mem_rvalid | input | 1 | Read data return strobe |
| mem_rdata | input | 64 | Read data |
| tx_valid | output | 1 | Response frame strobe |
| tx_len | output | 4 | Response length code |
| tx_data | output | 64 | Response payload |
| dev_reset | output | 1 | Device reset command pulse |
| chk_init | output | 1 | Checksum/verify initialise pulse |
| chk_run | output | 1 | Check-and-run pulse |

## Verification
Some properties are checked on every cycle:
- a write request never leaves while the unlock bit is clear;
- no request is issued without a prior idle cycle from the sequencer;
- the busy flag only rises after a frame arrives;
- at most one command strobe is active at a time;
- responses are always empty or eight bytes long;
- the write-only build never transmits.

Other behaviour can only be shown by the bench's frame sequences:
- the pointer stepping and 24-bit wrap;
- the erase flags at 64-byte boundaries;
- partial control loads by length;
- the acknowledge choice taken from the freshly written mode byte;
- the readback layouts.

// File: rtl/bce_pkg.sv
package bce_pkg;
    localparam int NB      = 8;
    localparam int DATA_W  = 8 * NB;
    localparam int ID_W    = 29;
    localparam int LEN_W   = 4;
    localparam int ADDR_W  = 24;
    localparam int ROW_B   = 64;
    localparam int ROW_W   = $clog2(ROW_B);

    // control byte positions
    localparam int IDX_MODE = 4;
    localparam int IDX_CMD  = 5;

    // mode bits
    localparam int M_UNLOCK = 0;
    localparam int M_EONLY  = 1;
    localparam int M_AERASE = 2;
    localparam int M_AINC   = 3;
    localparam int M_ACK    = 4;
    localparam logic [7:0] MODE_RST = 8'h1C;

    typedef enum logic [7:0] {
        CMD_NOP   = 8'h00,
        CMD_RESET = 8'h01,
        CMD_INIT  = 8'h02,
        CMD_RUN   = 8'h03
    } cmd_e;

    typedef struct packed {
        logic              pend_rd;
        logic              mem_req;
        logic              mem_wr;
        logic              mem_erase;
        logic              mem_eonly;
        logic [ADDR_W-1:0] mem_addr;
        logic [LEN_W-1:0]  mem_len;
        logic [DATA_W-1:0] mem_wdata;
        logic              tx_valid;
        logic [LEN_W-1:0]  tx_len;
        logic [DATA_W-1:0] tx_data;
        logic              p_reset;
        logic              p_init;
        logic              p_run;
    } eng_st_t;
endpackage

// File: rtl/bce_frame_buf.sv
module bce_frame_buf
    import bce_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ID_W-1:0]   in_id,
    input  logic [LEN_W-1:0]  in_len,
    input  logic [DATA_W-1:0] in_data,
    input  logic              take,
    output logic              out_valid,
    output logic [ID_W-1:0]   out_id,
    output logic [LEN_W-1:0]  out_len,
    output logic [DATA_W-1:0] out_data
);
    typedef struct packed {
        logic              v;
        logic [ID_W-1:0]   id;
        logic [LEN_W-1:0]  len;
        logic [DATA_W-1:0] data;
    } fb_t;

    fb_t fb_d, fb_q;

    always_comb begin
        fb_d = fb_q;
        if (take) fb_d.v = 1'b0;
        if (!fb_q.v && in_valid) begin
            fb_d.v    = 1'b1;
            fb_d.id   = in_id;
            fb_d.len  = in_len;
            fb_d.data = in_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fb_q <= '0;
        else        fb_q <= fb_d;
    end

    assign out_valid = fb_q.v;
    assign out_id    = fb_q.id;
    assign out_len   = fb_q.len;
    assign out_data  = fb_q.data;
endmodule

// File: rtl/bce_ctrl_regs.sv
module bce_ctrl_regs
    import bce_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NB-1:0]     byte_we,
    input  logic [DATA_W-1:0] byte_wd,
    input  logic              ptr_we,
    input  logic [ADDR_W-1:0] ptr_wd,
    output logic [DATA_W-1:0] regs_q
);
    localparam int PTR_B = ADDR_W / 8;

    for (genvar i = 0; i < NB; i++) begin : g_byte
        localparam logic [7:0] RV = (i == IDX_MODE) ? MODE_RST : 8'h00;
        logic [7:0] b_d, b_q;
        always_comb begin
            b_d = b_q;
            if (byte_we[i]) b_d = byte_wd[8*i +: 8];
            if (i < PTR_B && ptr_we) b_d = ptr_wd[8*(i % PTR_B) +: 8];
        end
        always_ff @(posedge clk) begin
            if (!rst_n) b_q <= RV;
            else        b_q <= b_d;
        end
        assign regs_q[8*i +: 8] = b_q;
    end
endmodule

// File: rtl/bootcmd_engine.sv
module bootcmd_engine
    import bce_pkg::*;
#(
    parameter bit READ_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [ID_W-1:0]   rx_id,
    input  logic [LEN_W-1:0]  rx_len,
    input  logic [DATA_W-1:0] rx_data,
    output logic              rx_busy,
    input  logic              mem_idle,
    output logic              mem_req,
    output logic              mem_wr,
    output logic              mem_erase,
    output logic              mem_erase_only,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LEN_W-1:0]  mem_len,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              tx_valid,
    output logic [LEN_W-1:0]  tx_len,
    output logic [DATA_W-1:0] tx_data,
    output logic              dev_reset,
    output logic              chk_init,
    output logic              chk_run
);
    localparam logic [LEN_W-1:0] FULL = LEN_W'(NB);

    logic              fb_valid;
    logic [ID_W-1:0]   fb_id;
    logic [LEN_W-1:0]  fb_len;
    logic [DATA_W-1:0] fb_data;
    logic              go;
    logic [NB-1:0]     byte_we;
    logic              ptr_we;
    logic [ADDR_W-1:0] ptr_wd;
    logic [DATA_W-1:0] ctrl_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [7:0]        mode_q;
    logic [7:0]        cmd_q;
    eng_st_t           st_d, st_q;

    bce_frame_buf u_buf (
        .clk(clk), .rst_n(rst_n),
        .in_valid(rx_valid), .in_id(rx_id), .in_len(rx_len), .in_data(rx_data),
        .take(go),
        .out_valid(fb_valid), .out_id(fb_id), .out_len(fb_len), .out_data(fb_data)
    );

    bce_ctrl_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .byte_we(byte_we), .byte_wd(fb_data),
        .ptr_we(ptr_we), .ptr_wd(ptr_wd),
        .regs_q(ctrl_q)
    );

    assign ptr_q  = ctrl_q[ADDR_W-1:0];
    assign mode_q = ctrl_q[8*IDX_MODE +: 8];
    assign cmd_q  = ctrl_q[8*IDX_CMD +: 8];
    assign go     = fb_valid && mem_idle && !st_q.pend_rd;

    always_comb begin
        logic             is_get, is_data;
        logic [LEN_W-1:0] len_c;
        logic [7:0]       new_mode, new_cmd;

        is_get   = fb_id[1];
        is_data  = fb_id[0];
        len_c    = (fb_len > FULL) ? FULL : fb_len;
        new_mode = mode_q;
        new_cmd  = cmd_q;
        byte_we  = '0;
        ptr_we   = 1'b0;
        ptr_wd   = ptr_q + ADDR_W'(len_c);

        st_d          = st_q;
        st_d.mem_req  = 1'b0;
        st_d.tx_valid = 1'b0;
        st_d.p_reset  = 1'b0;
        st_d.p_init   = 1'b0;
        st_d.p_run    = 1'b0;

        if (st_q.pend_rd && mem_rvalid) begin
            st_d.pend_rd  = 1'b0;
            st_d.tx_valid = 1'b1;
            st_d.tx_len   = FULL;
            st_d.tx_data  = mem_rdata;
        end

        if (go) begin
            if (!is_get) begin
                if (!is_data) begin
                    for (int i = 0; i < NB; i++) byte_we[i] = (i < int'(len_c));
                    if (byte_we[IDX_MODE]) new_mode = fb_data[8*IDX_MODE +: 8];
                    if (byte_we[IDX_CMD])  new_cmd  = fb_data[8*IDX_CMD +: 8];
                    case (new_cmd)
                        CMD_RESET: st_d.p_reset = 1'b1;
                        CMD_INIT:  st_d.p_init  = 1'b1;
                        CMD_RUN:   st_d.p_run   = 1'b1;
                        default:   ;
                    endcase
                end else if (mode_q[M_UNLOCK] && len_c != '0) begin
                    st_d.mem_req   = 1'b1;
                    st_d.mem_wr    = 1'b1;
                    st_d.mem_addr  = ptr_q;
                    st_d.mem_len   = len_c;
                    st_d.mem_wdata = fb_data;
                    st_d.mem_erase = mode_q[M_AERASE] && (ptr_q[ROW_W-1:0] == '0);
                    st_d.mem_eonly = mode_q[M_EONLY];
                    ptr_we         = mode_q[M_AINC];
                end
                if (READ_EN && new_mode[M_ACK]) begin
                    st_d.tx_valid = 1'b1;
                    st_d.tx_len   = '0;
                    st_d.tx_data  = '0;
                end
            end else if (READ_EN) begin
                if (is_data) begin
                    st_d.mem_req   = 1'b1;
                    st_d.mem_wr    = 1'b0;
                    st_d.mem_addr  = ptr_q;
                    st_d.mem_len   = FULL;
                    st_d.mem_erase = 1'b0;
                    st_d.mem_eonly = 1'b0;
                    st_d.pend_rd   = 1'b1;
                    ptr_wd         = ptr_q + ADDR_W'(NB);
                    ptr_we         = mode_q[M_AINC];
                end else begin
                    st_d.tx_valid = 1'b1;
                    st_d.tx_len   = FULL;
                    st_d.tx_data  = '0;
                    st_d.tx_data[ADDR_W-1:0]         = ptr_q;
                    st_d.tx_data[8*IDX_MODE +: 8]    = mode_q;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_busy        = fb_valid;
    assign mem_req        = st_q.mem_req;
    assign mem_wr         = st_q.mem_wr;
    assign mem_erase      = st_q.mem_erase;
    assign mem_erase_only = st_q.mem_eonly;
    assign mem_addr       = st_q.mem_addr;
    assign mem_len        = st_q.mem_len;
    assign mem_wdata      = st_q.mem_wdata;
    assign tx_valid       = st_q.tx_valid;
    assign tx_len         = st_q.tx_len;
    assign tx_data        = st_q.tx_data;
    assign dev_reset      = st_q.p_reset;
    assign chk_init       = st_q.p_init;
    assign chk_run        = st_q.p_run;
endmodule

// File: rtl/bce_engine_chk.sv
module bce_engine_chk #(
    parameter bit READ_EN = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic       rx_busy,
    input logic       mem_idle,
    input logic       mem_req,
    input logic       mem_wr,
    input logic [7:0] mode_q,
    input logic       tx_valid,
    input logic [3:0] tx_len,
    input logic       dev_reset,
    input logic       chk_init,
    input logic       chk_run
);
    a_r4_locked_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_wr) |-> $past(mode_q[0]));

    a_r12_req_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> $past(mem_idle));

    a_r12_busy_from_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_busy) |-> $past(rx_valid));

    a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dev_reset, chk_init, chk_run}));

    a_r8_tx_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_len == 4'd0 || tx_len == 4'd8));

    a_r11_wo_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (READ_EN == 1'b0) |-> !tx_valid);
endmodule

bind bootcmd_engine bce_engine_chk #(.READ_EN(READ_EN)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_busy(rx_busy),
    .mem_idle(mem_idle), .mem_req(mem_req), .mem_wr(mem_wr), .mode_q(mode_q),
    .tx_valid(tx_valid), .tx_len(tx_len), .dev_reset(dev_reset),
    .chk_init(chk_init), .chk_run(chk_run)
);

// File: tb/bootcmd_engine_bench.sv
module bootcmd_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [28:0] rx_id = '0;
    logic [3:0]  rx_len = '0;
    logic [63:0] rx_data = '0;
    logic        mem_idle = 1'b1;
    logic        mem_rvalid = 1'b0;
    logic [63:0] mem_rdata = '0;

    logic        rx_busy, mem_req, mem_wr, mem_erase, mem_eonly;
    logic [23:0] mem_addr;
    logic [3:0]  mem_len, tx_len;
    logic [63:0] mem_wdata, tx_data;
    logic        tx_valid, dev_reset, chk_init, chk_run;

    logic        w_busy, w_req, w_wr, w_er, w_eo, w_tx, w_rst, w_init, w_run;
    logic [23:0] w_addr;
    logic [3:0]  w_len, w_txlen;
    logic [63:0] w_wdata, w_txdata;

    int n_chk = 0, n_fail = 0, wo_tx_seen = 0;
    bit done = 0;

    always #5 clk = ~clk;

    bootcmd_engine #(.READ_EN(1'b1)) u_bootcmd_engine (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_id(rx_id), .rx_len(rx_len),
        .rx_data(rx_data), .rx_busy(rx_busy), .mem_idle(mem_idle), .mem_req(mem_req),
        .mem_wr(mem_wr), .mem_erase(mem_erase), .mem_erase_only(mem_eonly),
        .mem_addr(mem_addr), .mem_len(mem_len), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
        .tx_len(tx_len), .tx_data(tx_data), .dev_reset(dev_reset),
        .chk_init(chk_init), .chk_run(chk_run)
    );

    bootcmd_engine #(.READ_EN(1'b0)) u_bootcmd_engine_wo (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_id(rx_id), .rx_len(rx_len),
        .rx_data(rx_data), .rx_busy(w_busy), .mem_idle(mem_idle), .mem_req(w_req),
        .mem_wr(w_wr), .mem_erase(w_er), .mem_erase_only(w_eo),
        .mem_addr(w_addr), .mem_len(w_len), .mem_wdata(w_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .tx_valid(w_tx),
        .tx_len(w_txlen), .tx_data(w_txdata), .dev_reset(w_rst),
        .chk_init(w_init), .chk_run(w_run)
    );

    always @(posedge clk) if (rst_n && w_tx) wo_tx_seen++;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // send one frame; returns at the negedge after the capturing edge
    task automatic send(input logic [1:0] id, input logic [3:0] len, input logic [63:0] d);
        @(negedge clk);
        rx_valid = 1'b1; rx_id = {27'b0, id}; rx_len = len; rx_data = d;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    // control read; returns the payload sampled when the response appears
    task automatic read_ctrl(output logic [63:0] d);
        send(2'b10, 4'd0, '0);
        @(negedge clk);
        chk("R10 readback valid", 64'(tx_valid), 64'd1);
        d = tx_data;
    endtask

    typedef struct packed {
        logic [1:0]  id;
        logic [3:0]  len;
        logic [63:0] data;
        logic        req;
        logic [23:0] addr;
        logic        er;
        logic        eo;
        logic        tx;
        logic [3:0]  txlen;
        logic [63:0] txdata;
    } vec_t;

    localparam vec_t TBL [7] = '{
        '{2'b01, 4'd8, 64'h1122334455667788, 1'b0, 24'h0,   1'b0, 1'b0, 1'b1, 4'd0, 64'h0},
        '{2'b00, 4'd5, 64'h0000001D00000040, 1'b0, 24'h0,   1'b0, 1'b0, 1'b1, 4'd0, 64'h0},
        '{2'b01, 4'd8, 64'hA5A5A5A5A5A5A5A5, 1'b1, 24'h40,  1'b1, 1'b0, 1'b1, 4'd0, 64'h0},
        '{2'b01, 4'd4, 64'h00000000CAFEF00D, 1'b1, 24'h48,  1'b0, 1'b0, 1'b1, 4'd0, 64'h0},
        '{2'b10, 4'd0, 64'h0,                1'b0, 24'h0,   1'b0, 1'b0, 1'b1, 4'd8, 64'h0000001D0000004C},
        '{2'b00, 4'd5, 64'h0000001F00000080, 1'b0, 24'h0,   1'b0, 1'b0, 1'b1, 4'd0, 64'h0},
        '{2'b01, 4'd8, 64'h0102030405060708, 1'b1, 24'h80,  1'b1, 1'b1, 1'b1, 4'd0, 64'h0}
    };

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [63:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R3 reset state
        chk("R3 busy at reset", 64'(rx_busy), 64'd0);
        chk("R3 no request at reset", 64'(mem_req), 64'd0);
        chk("R3 no tx at reset", 64'(tx_valid), 64'd0);
        read_ctrl(rd);
        chk("R3 R10 reset pointer and mode", rd, 64'h0000001C00000000);
        @(negedge clk);

        // table walk: R1 R4 R5 R6 R8 R10
        foreach (TBL[k]) begin
            send(TBL[k].id, TBL[k].len, TBL[k].data);
            @(negedge clk);
            chk("R1 R4 R5 request", 64'(mem_req), 64'(TBL[k].req));
            if (TBL[k].req) begin
                chk("R5 write dir", 64'(mem_wr), 64'd1);
                chk("R5 R6 address", 64'(mem_addr), 64'(TBL[k].addr));
                chk("R5 length", 64'(mem_len), 64'(TBL[k].len));
                chk("R5 payload", mem_wdata, TBL[k].data);
                chk("R5 erase flag", 64'(mem_erase), 64'(TBL[k].er));
                chk("R5 erase-only flag", 64'(mem_eonly), 64'(TBL[k].eo));
            end
            chk("R8 R10 tx", 64'(tx_valid), 64'(TBL[k].tx));
            if (TBL[k].tx) chk("R8 R10 tx len", 64'(tx_len), 64'(TBL[k].txlen));
            if (TBL[k].txlen == 4'd8) chk("R10 ctrl frame", tx_data, TBL[k].txdata);
            @(negedge clk);
        end

        // R2 partial control load
        send(2'b00, 4'd1, 64'hFFFFFFFFFFFFFF11);
        @(negedge clk);
        read_ctrl(rd);
        chk("R2 partial load", rd, 64'h0000001F00000011);

        // R7 commands
        send(2'b00, 4'd8, 64'h0000021D00000000);
        @(negedge clk);
        chk("R7 init pulse", 64'({dev_reset, chk_init, chk_run}), 64'b010);
        send(2'b00, 4'd8, 64'h0000031D00000000);
        @(negedge clk);
        chk("R7 run pulse", 64'({dev_reset, chk_init, chk_run}), 64'b001);
        @(negedge clk);
        chk("R7 pulse one cycle", 64'({dev_reset, chk_init, chk_run}), 64'b000);
        send(2'b00, 4'd8, 64'h0000011D00000000);
        @(negedge clk);
        chk("R7 reset pulse", 64'({dev_reset, chk_init, chk_run}), 64'b100);
        send(2'b00, 4'd8, 64'h0000071D00000000);
        @(negedge clk);
        chk("R7 undefined code", 64'({dev_reset, chk_init, chk_run}), 64'b000);

        // R6 wrap
        send(2'b00, 4'd5, 64'h0000001D00FFFFFC);
        @(negedge clk);
        send(2'b01, 4'd8, 64'h5555AAAA5555AAAA);
        @(negedge clk);
        chk("R6 wrap request addr", 64'(mem_addr), 64'hFFFFFC);
        read_ctrl(rd);
        chk("R6 wrapped pointer", rd, 64'h0000001D00000004);

        // R6 auto-increment off
        send(2'b00, 4'd5, 64'h0000001500000100);
        @(negedge clk);
        send(2'b01, 4'd8, 64'h1234);
        @(negedge clk);
        chk("R5 aligned erase", 64'(mem_erase), 64'd1);
        read_ctrl(rd);
        chk("R6 no increment", rd, 64'h0000001500000100);

        // R9 memory read, R11 write-only ignores it
        send(2'b00, 4'd5, 64'h0000001D00000200);
        @(negedge clk);
        send(2'b11, 4'd0, '0);
        @(negedge clk);
        chk("R9 read request", 64'({mem_req, mem_wr}), 64'b10);
        chk("R9 read addr", 64'(mem_addr), 64'h200);
        chk("R9 read len", 64'(mem_len), 64'd8);
        chk("R11 wo no read request", 64'(w_req), 64'd0);
        mem_rvalid = 1'b1; mem_rdata = 64'hDEADBEEF01234567;
        @(negedge clk);
        mem_rvalid = 1'b0;
        chk("R9 read frame", 64'({tx_valid, tx_len}), 64'h18);
        chk("R9 read data", tx_data, 64'hDEADBEEF01234567);
        @(negedge clk);
        read_ctrl(rd);
        chk("R6 read increments", rd, 64'h0000001D00000208);

        // R8 acknowledge off
        send(2'b00, 4'd5, 64'h0000000D00000300);
        @(negedge clk);
        chk("R8 no ack on ctrl", 64'(tx_valid), 64'd0);
        send(2'b01, 4'd8, 64'h77);
        @(negedge clk);
        chk("R8 no ack on data", 64'(tx_valid), 64'd0);
        chk("R8 write still issued", 64'(mem_req), 64'd1);

        // R12 hold while sequencer busy
        @(negedge clk);
        mem_idle = 1'b0;
        send(2'b01, 4'd8, 64'h99);
        chk("R12 busy raised", 64'(rx_busy), 64'd1);
        @(negedge clk);
        @(negedge clk);
        chk("R12 held no request", 64'(mem_req), 64'd0);
        chk("R12 still busy", 64'(rx_busy), 64'd1);
        mem_idle = 1'b1;
        @(negedge clk);
        chk("R12 released request", 64'(mem_req), 64'd1);
        chk("R12 released addr", 64'(mem_addr), 64'h308);
        chk("R12 busy cleared", 64'(rx_busy), 64'd0);

        repeat (3) @(negedge clk);
        chk("R11 wo never transmits", 64'(wo_tx_seen), 64'd0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule